// File: doc/BRIEF.md
# Double-Buffered 180-Degree Frame Rotator

This block turns a raster pixel stream upside down and mirror-reversed, which is a 180-degree rotation. It holds two small frame stores. Each incoming frame goes into one store. At the same time, the store that holds the frame before it is played out from its last pixel back to its first. At every incoming frame start the two stores swap roles, so the output is the rotated image one frame late.

While rotation is on, the block raises a cut signal that isolates the live upstream path from the downstream input, so that only the rotated stream reaches downstream. When rotation is off, the block copies its input to its output with one register of delay and drops the cut signal.

Control is a four-state machine:
- `S_PASS`: rotation off.
- `S_ARM`: enabled, waiting for a frame start.
- `S_FILL`: capturing the first frame, with no output.
- `S_FLIP`: steady double-buffered operation.

Its transitions are:
- **enable**: `S_PASS`→`S_ARM` when `flip_en` is high.
- **first start**: `S_ARM`→`S_FILL` on a valid frame-start pixel.
- **second start**: `S_FILL`→`S_FLIP` on the next valid frame-start pixel.
- **disable**: any other state→`S_PASS` when `flip_en` is low.

`S_FLIP` stays in itself on every later frame start and swaps the stores.

Top module: `frame_flip_pp`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `out_vld`, `out_sof` and `live_cut` are 0.
- R2: When `flip_en` is sampled low at a clock edge, after that edge `out_vld` equals the sampled `in_vld`, `out_pix` equals `in_pix`, and `out_sof` equals `in_sof & in_vld`.
- R3: After each clock edge, `live_cut` equals the value `flip_en` had at that edge (1 = live path cut).
- R4: After enabling, a frame start is a pixel with both `in_vld` and `in_sof` at 1. The first frame start begins capture into store A. `out_vld` stays 0 until the second frame start.
- R5: From the second frame start on, every frame start swaps the stores. The new frame is written to one store while the other store, which holds the previous frame, is read. The same store is never read and written in one cycle, except for the frame-start pixel itself.
- R6: A readout starts the cycle after a frame start. It emits W*H pixels on consecutive cycles, at addresses W*H-1 down to 0 (write address 0 is the frame-start pixel). `out_sof` is 1 only with the first of these pixels. Input frames must start at least W*H cycles apart.
- R7: A short frame (fewer than W*H pixels) is still read out over all W*H addresses. Addresses it did not write keep the older content of that store.
- R8: Cycles with `in_vld` low write nothing. Pixels past the W*H-th of a frame are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flip_en | input | 1 | 1 = rotate, 0 = pass through |
| in_vld | input | 1 | Input pixel valid |
| in_sof | input | 1 | Input frame start, qualified by `in_vld` |
| in_pix | input | PIX_W | Input pixel value |
| out_vld | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output frame start |
| out_pix | output | PIX_W | Output pixel value |
| live_cut | output | 1 | 1 = live upstream path isolated from downstream |

## Verification
The bench builds the block with a 4×3 frame of 8-bit pixels. This keeps each store at twelve entries, so every readout, every store swap and the full pass–rotate–pass–rotate cycle fit in a few hundred clocks.

At that size the bench can run a number of cases:
- a short eight-pixel frame whose missing tail comes from the frame written two starts earlier;
- a fourteen-pixel frame whose extra pixels must vanish;
- frames with valid bubbles;
- a re-enable that must begin again in the fill phase.

// File: rtl/ffp_pkg.sv
package ffp_pkg;

    typedef enum logic [1:0] {
        S_PASS = 2'd0,
        S_ARM  = 2'd1,
        S_FILL = 2'd2,
        S_FLIP = 2'd3
    } ffp_state_t;

endpackage

// File: rtl/ffp_bank.sv
module ffp_bank #(
    parameter int PIX_W  = 8,
    parameter int DEPTH  = 12,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [PIX_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [PIX_W-1:0]  rdata
);

    logic [PIX_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/ffp_ctrl.sv
module ffp_ctrl
    import ffp_pkg::*;
#(
    parameter int N      = 12,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flip_en,
    input  logic              in_vld,
    input  logic              in_sof,
    output ffp_state_t        st,
    output logic              wr_en,
    output logic              wr_sel,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CNT_W-1:0]  wr_cnt,
    output logic              rd_on,
    output logic              rd_sel,
    output logic [ADDR_W-1:0] rd_addr
);

    ffp_state_t st_nx;
    logic       wbuf;
    logic       frame_go;
    logic       swap_now;

    assign frame_go = in_vld && in_sof;
    assign swap_now = frame_go && (st == S_FILL || st == S_FLIP);

    // next-state decision
    always_comb begin
        st_nx = st;
        unique case (st)
            S_PASS: if (flip_en) st_nx = S_ARM;
            S_ARM: begin
                if (!flip_en)      st_nx = S_PASS;
                else if (frame_go) st_nx = S_FILL;
            end
            S_FILL: begin
                if (!flip_en)      st_nx = S_PASS;
                else if (frame_go) st_nx = S_FLIP;
            end
            S_FLIP: if (!flip_en) st_nx = S_PASS;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_PASS;
        else        st <= st_nx;
    end

    // write side
    assign wr_sel  = swap_now ? ~wbuf : wbuf;
    assign wr_addr = in_sof ? '0 : wr_cnt[ADDR_W-1:0];

    always_comb begin
        wr_en = 1'b0;
        if (flip_en && in_vld && (in_sof || wr_cnt < CNT_W'(N))) begin
            unique case (st)
                S_PASS:         wr_en = 1'b0;
                S_ARM:          wr_en = in_sof;
                S_FILL, S_FLIP: wr_en = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbuf   <= 1'b0;
            wr_cnt <= '0;
        end else if (!flip_en) begin
            wbuf   <= 1'b0;
            wr_cnt <= '0;
        end else begin
            wbuf <= wr_sel;
            if (wr_en) wr_cnt <= CNT_W'(wr_addr) + CNT_W'(1);
        end
    end

    // read side: reverse sweep of the store just completed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_on   <= 1'b0;
            rd_sel  <= 1'b0;
            rd_addr <= '0;
        end else if (!flip_en) begin
            rd_on <= 1'b0;
        end else if (swap_now) begin
            rd_on   <= 1'b1;
            rd_sel  <= wbuf;
            rd_addr <= ADDR_W'(N - 1);
        end else if (rd_on) begin
            if (rd_addr == '0) rd_on   <= 1'b0;
            else               rd_addr <= rd_addr - ADDR_W'(1);
        end
    end

endmodule

// File: rtl/frame_flip_pp.sv
module frame_flip_pp
    import ffp_pkg::*;
#(
    parameter int IMG_W = 4,
    parameter int IMG_H = 3,
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flip_en,
    input  logic             in_vld,
    input  logic             in_sof,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_vld,
    output logic             out_sof,
    output logic [PIX_W-1:0] out_pix,
    output logic             live_cut
);

    localparam int N      = IMG_W * IMG_H;
    localparam int ADDR_W = (N > 1) ? $clog2(N) : 1;
    localparam int CNT_W  = $clog2(N + 1);

    ffp_state_t        st;
    logic              wr_en, wr_sel, rd_on, rd_sel;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [CNT_W-1:0]  wr_cnt;
    logic [PIX_W-1:0]  bank_q [2];
    logic [PIX_W-1:0]  rd_data;

    ffp_ctrl #(.N(N), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flip_en(flip_en),
        .in_vld(in_vld), .in_sof(in_sof), .st(st),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_cnt(wr_cnt),
        .rd_on(rd_on), .rd_sel(rd_sel), .rd_addr(rd_addr)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        ffp_bank #(.PIX_W(PIX_W), .DEPTH(N), .ADDR_W(ADDR_W)) u_bank (
            .clk(clk),
            .we(wr_en && (wr_sel == b[0])),
            .waddr(wr_addr),
            .wdata(in_pix),
            .raddr(rd_addr),
            .rdata(bank_q[b])
        );
    end

    assign rd_data  = rd_sel ? bank_q[1] : bank_q[0];
    assign live_cut = (st != S_PASS);

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_sof <= 1'b0;
            out_pix <= '0;
        end else if (!flip_en) begin
            out_vld <= in_vld;
            out_sof <= in_sof && in_vld;
            out_pix <= in_pix;
        end else if (rd_on) begin
            out_vld <= 1'b1;
            out_sof <= (rd_addr == ADDR_W'(N - 1));
            out_pix <= rd_data;
        end else begin
            out_vld <= 1'b0;
            out_sof <= 1'b0;
            out_pix <= '0;
        end
    end

endmodule

// File: rtl/frame_flip_pp_chk.sv
module frame_flip_pp_chk
    import ffp_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int N      = 12,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flip_en,
    input logic              in_vld,
    input logic              in_sof,
    input logic [PIX_W-1:0]  in_pix,
    input logic              out_vld,
    input logic              out_sof,
    input logic [PIX_W-1:0]  out_pix,
    input logic              live_cut,
    input ffp_state_t        st,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [CNT_W-1:0]  wr_cnt,
    input logic              rd_on,
    input logic              rd_sel,
    input logic [ADDR_W-1:0] rd_addr
);

    // R2
    pass_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flip_en |=> (out_vld == $past(in_vld)) && (out_pix == $past(in_pix)));

    // R3
    cut_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (live_cut == $past(flip_en)));

    // R4
    no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_en && st != S_FLIP) |=> !out_vld);

    // R5
    split_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_on && !(in_vld && in_sof)) |-> (wr_sel != rd_sel));

    // R6
    sof_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_vld);

    // R6
    rd_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_en && rd_on && !(in_vld && in_sof) && rd_addr != '0)
        |=> rd_on && (rd_addr == $past(rd_addr) - ADDR_W'(1)));

    // R8
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= CNT_W'(N));

endmodule

bind frame_flip_pp frame_flip_pp_chk #(
    .PIX_W(PIX_W), .N(N), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flip_en(flip_en), .in_vld(in_vld),
    .in_sof(in_sof), .in_pix(in_pix), .out_vld(out_vld), .out_sof(out_sof),
    .out_pix(out_pix), .live_cut(live_cut), .st(st), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_cnt(wr_cnt), .rd_on(rd_on), .rd_sel(rd_sel),
    .rd_addr(rd_addr)
);

// File: tb/frame_flip_pp_tb.sv
module frame_flip_pp_tb;

    localparam int CLK_P = 10;
    localparam int W     = 4;
    localparam int H     = 3;
    localparam int PW    = 8;
    localparam int N     = W * H;
    localparam int LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flip_en = 1'b0;
    logic          in_vld = 1'b0;
    logic          in_sof = 1'b0;
    logic [PW-1:0] in_pix = '0;
    logic          out_vld, out_sof, live_cut;
    logic [PW-1:0] out_pix;

    int n_chk = 0;
    int n_bad = 0;
    int n_out = 0;
    bit done  = 1'b0;

    logic [PW-1:0] q_pix [$];
    logic          q_sof [$];
    string         q_tag [$];

    logic [PW-1:0] mbuf [2][N];
    string         btag [2];
    int            phase = 0;
    int            wsel  = 0;
    int            wcnt  = 0;

    always #(CLK_P/2) clk = ~clk;

    frame_flip_pp #(.IMG_W(W), .IMG_H(H), .PIX_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .flip_en(flip_en), .in_vld(in_vld),
        .in_sof(in_sof), .in_pix(in_pix), .out_vld(out_vld),
        .out_sof(out_sof), .out_pix(out_pix), .live_cut(live_cut)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    // monitor: pop and compare
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n && out_vld) begin
            n_out++;
            if (q_pix.size() == 0) begin
                check(1'b0, "R4 unexpected output", int'(out_pix), 0);
            end else begin
                automatic logic [PW-1:0] ep = q_pix.pop_front();
                automatic logic          es = q_sof.pop_front();
                automatic string         et = q_tag.pop_front();
                check(out_pix == ep, {et, " pixel"}, int'(out_pix), int'(ep));
                check(out_sof == es, {et, " R6 sof"}, int'(out_sof), int'(es));
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_vld = 1'b0;
            in_sof = 1'b0;
        end
    endtask

    // driver: drives one frame and pushes expected items
    task automatic send_frame(input int fid, input int npix, input int bub,
                              input int tail, input string tag);
        for (int i = 0; i < npix; i++) begin
            automatic logic [PW-1:0] v = PW'((fid * 37 + i * 5) & 255);
            @(negedge clk);
            in_vld = 1'b1;
            in_sof = (i == 0);
            in_pix = v;
            if (!flip_en) begin
                q_pix.push_back(v);
                q_sof.push_back(i == 0);
                q_tag.push_back("R2");
            end else if (phase > 0) begin
                if (i == 0) begin
                    if (phase == 2) begin
                        for (int a = N - 1; a >= 0; a--) begin
                            q_pix.push_back(mbuf[wsel][a]);
                            q_sof.push_back(a == N - 1);
                            q_tag.push_back(btag[wsel]);
                        end
                        wsel = 1 - wsel;
                    end else begin
                        phase = 2;
                    end
                    wcnt = 0;
                    btag[wsel] = tag;
                end
                if (wcnt < N) begin
                    mbuf[wsel][wcnt] = v;
                    wcnt++;
                end
            end
            if (bub > 0 && (i % bub) == bub - 1) idle(1);
        end
        idle(tail);
    endtask

    task automatic set_en(input bit e);
        @(negedge clk);
        flip_en = e;
        in_vld  = 1'b0;
        in_sof  = 1'b0;
        phase   = e ? 1 : 0;
        wsel    = 0;
        idle(2);
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int seen;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        check(!out_vld && !out_sof && !live_cut, "R1 reset outputs",
              int'({out_vld, out_sof, live_cut}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #(CLK_P/4);
        check(!out_vld && !out_sof && !live_cut, "R1 after reset",
              int'({out_vld, out_sof, live_cut}), 0);

        // pass-through with bubbles
        send_frame(1, 5, 2, 2, "R2");
        send_frame(2, 6, 0, 3, "R2");
        check(live_cut == 1'b0, "R2 cut low in pass", int'(live_cut), 0);

        // rotate on
        set_en(1'b1);
        check(live_cut == 1'b1, "R3 cut high", int'(live_cut), 1);
        seen = n_out;
        send_frame(10, N, 0, 2, "R5");
        check(n_out == seen, "R4 no output during fill", n_out - seen, 0);
        send_frame(11, N, 3, 1, "R8");
        send_frame(12, N, 0, 1, "R5");
        send_frame(13, 8, 0, 6, "R7");
        send_frame(14, N + 2, 0, 1, "R8");
        send_frame(15, N, 0, N + 4, "R6");

        // rotate off, pass again
        set_en(1'b0);
        check(live_cut == 1'b0, "R3 cut low after disable", int'(live_cut), 0);
        send_frame(3, 4, 0, 3, "R2");

        // rotate on again: must refill first
        set_en(1'b1);
        seen = n_out;
        send_frame(20, N, 0, 1, "R4");
        check(n_out == seen, "R4 refill silent", n_out - seen, 0);
        send_frame(21, N, 2, N + 4, "R5");

        check(q_pix.size() == 0, "R6 all expected outputs seen", q_pix.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule